// File: doc/BRIEF.md
# Frame-Ordered Host Request Scheduler

This block sits between the logic that produces host transaction requests and the link engine that carries them out. Requests arrive on two push ports: one for periodic traffic (isochronous and interrupt) and one for non-periodic traffic (bulk and control). Each request names a token kind, a channel and a one-bit mark. Each push port feeds a queue of its own. The scheduler hands requests to the link one at a time through a registered output with a ready handshake.

Scheduling follows the frame tick. No request leaves before the first tick. After that, a request waiting in the periodic queue always wins over a non-periodic one. Within each queue, requests go out in the order they were written, so channel rotation comes from the order in which producers write. A request whose channel is not enabled when it reaches the head of its queue is removed without being issued. Periodic work still pending at the next tick has missed its frame: it is thrown away and a sticky flag records the miss.

Top module: `txn_sched`

## Requirements
- R1: After a synchronous reset, `out_valid`, both full flags, both overflow flags and `missed_per` are 0, and both empty flags are 1.
- R2: Until the first `sof_tick` after reset, `out_valid` stays 0, even when requests are queued and `link_rdy` is 1.
- R3: Requests from one queue are issued in the order they were pushed. The token code (00 OUT, 01 IN, 10 SETUP), the 4-bit channel and the mark bit leave the block unchanged.
- R4: Each time the output register is loaded, the periodic queue is served if it holds an entry. The non-periodic queue is served only when the periodic queue is empty.
- R5: An entry whose bit in `ch_en` (indexed by channel number) is 0 when it reaches the head of its queue is removed and never appears on the output.
- R6: While `out_valid` is 1 and `link_rdy` is 0, the request on the output holds its value. This does not apply in a `sof_tick` cycle.
- R7: A push to a queue that already holds 8 entries is dropped, and that queue's overflow flag is set and stays set until reset.
- R8: On `sof_tick`, every periodic entry still queued is dropped, and so is a periodic request held on the output. If anything was dropped, `missed_per` is set and stays set until reset. A periodic push made in the tick cycle is kept for the new frame.
- R9: A queue's full flag is 1 exactly when it holds 8 entries, and its empty flag is 1 exactly when it holds none. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_tick | input | 1 | One-cycle pulse at each frame or microframe start |
| per_push | input | 1 | Push a periodic request |
| per_tok | input | 2 | Token code of the periodic request |
| per_ch | input | 4 | Channel of the periodic request |
| per_mark | input | 1 | Mark bit of the periodic request |
| np_push | input | 1 | Push a non-periodic request |
| np_tok | input | 2 | Token code of the non-periodic request |
| np_ch | input | 4 | Channel of the non-periodic request |
| np_mark | input | 1 | Mark bit of the non-periodic request |
| ch_en | input | 16 | Channel enable mask |
| link_rdy | input | 1 | Link takes the output request when both this and out_valid are 1 |
| out_valid | output | 1 | Output request valid |
| out_tok | output | 2 | Token code of the output request |
| out_ch | output | 4 | Channel of the output request |
| out_mark | output | 1 | Mark bit of the output request |
| out_periodic | output | 1 | Output request came from the periodic queue |
| per_full | output | 1 | Periodic queue full |
| per_empty | output | 1 | Periodic queue empty |
| np_full | output | 1 | Non-periodic queue full |
| np_empty | output | 1 | Non-periodic queue empty |
| per_ovf | output | 1 | Sticky: a periodic push was dropped |
| np_ovf | output | 1 | Sticky: a non-periodic push was dropped |
| missed_per | output | 1 | Sticky: periodic work was dropped at a frame tick |

## Verification
The hardest situation to reach from the ports is the priority race, where both queues hold work at the moment the output register frees up. The output register fills as soon as any entry is present, so queuing requests one after another usually lets a non-periodic request reach the output first. The bench avoids this by pushing the first periodic request in the same cycle as the frame tick, while non-periodic entries already wait and `link_rdy` is low. The selection stalls in the tick cycle, so the first load after the tick must pick the periodic entry. The frame-miss path gets the same kind of setup: the bench stalls the link until a periodic request sits on the output and more wait behind it, and only then raises the tick.

// File: rtl/txn_sched_pkg.sv
package txn_sched_pkg;
  localparam int CH_W = 4;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10
  } tok_e;

  typedef struct packed {
    tok_e              tok;
    logic [CH_W-1:0]   ch;
    logic              mark;
  } req_t;

  localparam int REQ_W = $bits(req_t);
endpackage

// File: rtl/req_queue.sv
module req_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign drop    = push && full && !flush;
  assign do_push = push && (flush || !full);
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      rp  <= wp;
      wp  <= push ? step(wp) : wp;
      cnt <= push ? CW'(1) : '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import txn_sched_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           frame_on,
  input  logic           tick,
  input  logic           can_load,
  input  logic           per_empty,
  input  req_t           per_head,
  input  logic           np_empty,
  input  req_t           np_head,
  input  logic [NCH-1:0] ch_en,
  output logic           per_pop,
  output logic           np_pop,
  output logic           load,
  output req_t           load_req,
  output logic           load_per
);
  logic per_ok, np_ok;

  assign per_ok = ch_en[per_head.ch];
  assign np_ok  = ch_en[np_head.ch];

  always_comb begin
    per_pop  = 1'b0;
    np_pop   = 1'b0;
    load     = 1'b0;
    load_req = np_head;
    load_per = 1'b0;
    if (frame_on && !tick && can_load) begin
      if (!per_empty) begin
        per_pop  = 1'b1;
        load     = per_ok;
        load_req = per_head;
        load_per = 1'b1;
      end else if (!np_empty) begin
        np_pop   = 1'b1;
        load     = np_ok;
        load_req = np_head;
      end
    end
  end
endmodule

// File: rtl/txn_sched.sv
module txn_sched
  import txn_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NCH   = 1 << CH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof_tick,
  input  logic            per_push,
  input  logic [1:0]      per_tok,
  input  logic [CH_W-1:0] per_ch,
  input  logic            per_mark,
  input  logic            np_push,
  input  logic [1:0]      np_tok,
  input  logic [CH_W-1:0] np_ch,
  input  logic            np_mark,
  input  logic [NCH-1:0]  ch_en,
  input  logic            link_rdy,
  output logic            out_valid,
  output logic [1:0]      out_tok,
  output logic [CH_W-1:0] out_ch,
  output logic            out_mark,
  output logic            out_periodic,
  output logic            per_full,
  output logic            per_empty,
  output logic            np_full,
  output logic            np_empty,
  output logic            per_ovf,
  output logic            np_ovf,
  output logic            missed_per
);
  req_t per_in, np_in, per_head, np_head, load_req, out_req;
  logic per_pop, np_pop, load, load_per, can_load, frame_on;
  logic per_drop, np_drop;
  logic [REQ_W-1:0] per_raw, np_raw;

  assign per_in = '{tok: tok_e'(per_tok), ch: per_ch, mark: per_mark};
  assign np_in  = '{tok: tok_e'(np_tok),  ch: np_ch,  mark: np_mark};
  assign per_head = req_t'(per_raw);
  assign np_head  = req_t'(np_raw);

  req_queue #(.DEPTH(DEPTH), .W(REQ_W)) u_perq (
    .clk(clk), .rst(rst), .flush(sof_tick), .push(per_push),
    .wdata(per_in), .pop(per_pop), .rdata(per_raw),
    .empty(per_empty), .full(per_full), .drop(per_drop)
  );

  req_queue #(.DEPTH(DEPTH), .W(REQ_W)) u_npq (
    .clk(clk), .rst(rst), .flush(1'b0), .push(np_push),
    .wdata(np_in), .pop(np_pop), .rdata(np_raw),
    .empty(np_empty), .full(np_full), .drop(np_drop)
  );

  assign can_load = !out_valid || link_rdy;

  sched_pick #(.NCH(NCH)) u_pick (
    .frame_on(frame_on), .tick(sof_tick), .can_load(can_load),
    .per_empty(per_empty), .per_head(per_head),
    .np_empty(np_empty), .np_head(np_head), .ch_en(ch_en),
    .per_pop(per_pop), .np_pop(np_pop), .load(load),
    .load_req(load_req), .load_per(load_per)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_on     <= 1'b0;
      out_valid    <= 1'b0;
      out_periodic <= 1'b0;
      out_req      <= '0;
      per_ovf      <= 1'b0;
      np_ovf       <= 1'b0;
      missed_per   <= 1'b0;
    end else begin
      if (sof_tick) frame_on <= 1'b1;
      if (per_drop) per_ovf <= 1'b1;
      if (np_drop)  np_ovf  <= 1'b1;
      if (sof_tick && (!per_empty || (out_valid && out_periodic)))
        missed_per <= 1'b1;
      if (sof_tick && out_valid && out_periodic) begin
        out_valid <= 1'b0;
      end else if (can_load) begin
        out_valid <= load;
        if (load) begin
          out_req      <= load_req;
          out_periodic <= load_per;
        end
      end
    end
  end

  assign out_tok  = out_req.tok;
  assign out_ch   = out_req.ch;
  assign out_mark = out_req.mark;
endmodule

// File: rtl/txn_sched_chk.sv
module txn_sched_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            sof_tick,
  input logic            per_push,
  input logic            np_push,
  input logic            link_rdy,
  input logic            out_valid,
  input logic [1:0]      out_tok,
  input logic [CH_W-1:0] out_ch,
  input logic            out_mark,
  input logic            per_full,
  input logic            per_empty,
  input logic            np_full,
  input logic            np_empty,
  input logic            np_ovf,
  input logic            missed_per
);
  logic seen_tick;
  always_ff @(posedge clk) begin
    if (rst) seen_tick <= 1'b0;
    else if (sof_tick) seen_tick <= 1'b1;
  end

  // R2
  before_frame_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_tick |-> !out_valid);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !link_rdy && !sof_tick) |=>
      (out_valid && $stable(out_tok) && $stable(out_ch) && $stable(out_mark)));

  // R7
  np_overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (np_full && np_push) |=> np_ovf);

  // R7
  np_overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    np_ovf |=> np_ovf);

  // R8
  tick_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (sof_tick && !per_push) |=> per_empty);

  // R8
  missed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    missed_per |=> missed_per);

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(per_full && per_empty) && !(np_full && np_empty));
endmodule

bind txn_sched txn_sched_chk #(.CH_W(txn_sched_pkg::CH_W)) u_chk (
  .clk(clk), .rst(rst), .sof_tick(sof_tick), .per_push(per_push),
  .np_push(np_push), .link_rdy(link_rdy), .out_valid(out_valid),
  .out_tok(out_tok), .out_ch(out_ch), .out_mark(out_mark),
  .per_full(per_full), .per_empty(per_empty), .np_full(np_full),
  .np_empty(np_empty), .np_ovf(np_ovf), .missed_per(missed_per)
);

// File: tb/txn_sched_test.sv
module txn_sched_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, sof_tick = 1'b0, link_rdy = 1'b0;
  logic per_push = 1'b0, np_push = 1'b0, per_mark = 1'b0, np_mark = 1'b0;
  logic [1:0] per_tok = '0, np_tok = '0, out_tok;
  logic [3:0] per_ch = '0, np_ch = '0, out_ch;
  logic [15:0] ch_en = 16'hFFFF;
  logic out_valid, out_mark, out_periodic;
  logic per_full, per_empty, np_full, np_empty, per_ovf, np_ovf, missed_per;

  int n_tests = 0, n_fail = 0;
  logic [6:0] log_e [64];
  logic [6:0] exp_e [64];
  int n_log = 0, n_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_sched uut (
    .clk(clk), .rst(rst), .sof_tick(sof_tick),
    .per_push(per_push), .per_tok(per_tok), .per_ch(per_ch), .per_mark(per_mark),
    .np_push(np_push), .np_tok(np_tok), .np_ch(np_ch), .np_mark(np_mark),
    .ch_en(ch_en), .link_rdy(link_rdy), .out_valid(out_valid),
    .out_tok(out_tok), .out_ch(out_ch), .out_mark(out_mark),
    .out_periodic(out_periodic), .per_full(per_full), .per_empty(per_empty),
    .np_full(np_full), .np_empty(np_empty), .per_ovf(per_ovf),
    .np_ovf(np_ovf), .missed_per(missed_per)
  );

  // Record every handshake in mid-cycle
  always @(negedge clk) begin
    if (!rst && out_valid && link_rdy && n_log < 64) begin
      log_e[n_log] = {out_tok, out_ch, out_mark};
      n_log = n_log + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_per(input logic [1:0] t, input logic [3:0] c, input logic m);
    per_push = 1'b1; per_tok = t; per_ch = c; per_mark = m;
  endtask

  task automatic set_np(input logic [1:0] t, input logic [3:0] c, input logic m);
    np_push = 1'b1; np_tok = t; np_ch = c; np_mark = m;
  endtask

  task automatic idle_push();
    per_push = 1'b0; np_push = 1'b0;
  endtask

  task automatic expect_req(input logic [1:0] t, input logic [3:0] c, input logic m);
    exp_e[n_exp] = {t, c, m};
    n_exp++;
  endtask

  task automatic clear_logs();
    n_log = 0; n_exp = 0;
  endtask

  task automatic compare_log(input string req);
    check(n_log == n_exp, {req, " issue count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++)
      check(log_e[i] == exp_e[i], {req, " issued entry"}, int'(log_e[i]), int'(exp_e[i]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(per_empty == 1 && np_empty == 1, "R1 empty", {per_empty, np_empty}, 3);
    check(per_full == 0 && np_full == 0, "R1 full", {per_full, np_full}, 0);
    check(per_ovf == 0 && np_ovf == 0 && missed_per == 0, "R1 sticky", {per_ovf, np_ovf, missed_per}, 0);

    // R2: nothing before first tick
    link_rdy = 1'b1;
    set_np(2'b01, 4'd7, 1'b1);
    cyc(1); idle_push();
    cyc(6);
    check(n_log == 0 && out_valid == 0, "R2 no issue before tick", n_log, 0);
    check(np_empty == 0, "R9 np not empty", np_empty, 0);

    // R4: periodic wins when both are queued at the first load after tick
    link_rdy = 1'b0;
    clear_logs();
    set_np(2'b10, 4'd3, 1'b0);
    cyc(1);
    sof_tick = 1'b1;
    set_per(2'b01, 4'd9, 1'b0);
    set_np(2'b00, 4'd4, 1'b1);
    cyc(1);
    sof_tick = 1'b0;
    set_per(2'b00, 4'd10, 1'b1);
    np_push = 1'b0;
    cyc(1); idle_push();
    cyc(2);
    check(out_valid == 1 && out_periodic == 1, "R4 periodic first on output", {out_valid, out_periodic}, 3);
    check(out_ch == 4'd9, "R6 output held while link stalled", out_ch, 9);
    expect_req(2'b01, 4'd9, 1'b0);
    expect_req(2'b00, 4'd10, 1'b1);
    expect_req(2'b01, 4'd7, 1'b1);
    expect_req(2'b10, 4'd3, 1'b0);
    expect_req(2'b00, 4'd4, 1'b1);
    link_rdy = 1'b1;
    cyc(12);
    compare_log("R4");
    check(missed_per == 0, "R8 no miss on empty tick", missed_per, 0);

    // R3 / R5 sweep over masks, both queues, in write order
    for (int q = 0; q < 2; q++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] mask;
        mask = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h5555 : (k == 2) ? 16'h00F0 : 16'h8001;
        ch_en = mask;
        clear_logs();
        for (int i = 0; i < 16; i++) begin
          logic [1:0] t;
          t = 2'(i % 3);
          if (q == 0) set_per(t, 4'(i), 1'(i & 1)); else set_np(t, 4'(i), 1'(i & 1));
          if (mask[i]) expect_req(t, 4'(i), 1'(i & 1));
          cyc(1);
        end
        idle_push();
        cyc(8);
        compare_log((k == 0) ? "R3" : "R5");
      end
    end
    ch_en = 16'hFFFF;

    // R7 overflow on the non-periodic queue
    check(np_ovf == 0, "R7 no overflow yet", np_ovf, 0);
    link_rdy = 1'b0;
    clear_logs();
    for (int i = 0; i < 10; i++) begin
      set_np(2'b01, 4'(i), 1'b0);
      if (i < 9) expect_req(2'b01, 4'(i), 1'b0);
      cyc(1);
    end
    idle_push();
    cyc(1);
    check(np_full == 1, "R9 np full at 8", np_full, 1);
    check(np_ovf == 1, "R7 overflow flag", np_ovf, 1);
    check(per_ovf == 0, "R7 periodic overflow clear", per_ovf, 0);
    link_rdy = 1'b1;
    cyc(14);
    compare_log("R7");
    check(np_empty == 1 && np_full == 0, "R9 np drained", {np_empty, np_full}, 2);
    check(np_ovf == 1, "R7 overflow sticky", np_ovf, 1);

    // R8 missed periodic work at a tick
    link_rdy = 1'b0;
    clear_logs();
    for (int i = 0; i < 3; i++) begin
      set_per(2'b00, 4'(12 + i), 1'b0);
      cyc(1);
    end
    idle_push();
    cyc(3);
    check(out_valid == 1 && out_ch == 4'd12, "R6 periodic held", out_ch, 12);
    sof_tick = 1'b1;
    cyc(1);
    sof_tick = 1'b0;
    check(per_empty == 1, "R8 periodic queue flushed", per_empty, 1);
    check(out_valid == 0, "R8 held periodic withdrawn", out_valid, 0);
    check(missed_per == 1, "R8 missed flag", missed_per, 1);
    link_rdy = 1'b1;
    set_np(2'b10, 4'd5, 1'b1);
    expect_req(2'b10, 4'd5, 1'b1);
    cyc(1); idle_push();
    cyc(6);
    compare_log("R8");
    check(missed_per == 1, "R8 missed sticky", missed_per, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule